// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous request port inside a chip and an external asynchronous static RAM of 512K bytes. A client offers a request with a valid/ready handshake. The request carries a 19-bit address, a write flag and one byte of write data. The controller then runs the strobe sequence the RAM needs on the chip-select, output-enable and write-enable pins and on the shared 8-bit data bus. When the access is complete, it raises a single-cycle done pulse. For reads, the byte taken from the bus is presented in the same cycle as that pulse.

Every timed phase lasts a whole number of clock cycles, and each count is a module parameter. The integrator derives each count by rounding the RAM's minimum nanosecond figure up to whole clock periods: `ACC_CYC` for read access, `WP_CYC` for the write-enable pulse, `DS_CYC` for write-data setup and `TA_CYC` for bus turnaround. The controller drives the data bus only while the RAM output enable is high. After every read it keeps both chip select and output enable high for a turnaround window, so the RAM has released the bus before the next command starts.

The control state machine has six states:
- `ST_IDLE`: waits for a request.
- `ST_RD_ACCESS`: select low, output enable low.
- `ST_RD_TURN`: all strobes high while the bus settles.
- `ST_WR_SETUP`: select low, data driven, write enable still high.
- `ST_WR_PULSE`: write enable low.
- `ST_WR_HOLD`: write enable high again, select and data held.

It has these transitions:
- `ST_IDLE` to `ST_RD_ACCESS` on a read handshake.
- `ST_IDLE` to `ST_WR_SETUP` on a write handshake.
- `ST_RD_ACCESS` to `ST_RD_TURN` when the access timer expires.
- `ST_RD_TURN` to `ST_IDLE` when the turnaround timer expires.
- `ST_WR_SETUP` to `ST_WR_PULSE` after one cycle.
- `ST_WR_PULSE` to `ST_WR_HOLD` when the pulse timer expires.
- `ST_WR_HOLD` to `ST_IDLE` after one cycle.

The done pulse marks every return to `ST_IDLE`.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, chip select, output enable and write enable are all high (inactive), the data drivers are off, `req_ready` is high and `rsp_done` is low.
- R2: `req_ready` is high exactly when the controller is idle. It falls in the cycle after a request is accepted and stays low until the cycle in which `rsp_done` is high. `rsp_done` is high for a single cycle, and a new request may be accepted in that same cycle.
- R3: A read holds chip select and output enable low, with write enable high, for exactly `ACC_CYC` cycles. The bus byte present at the end of that window appears on `rsp_rdata` with `rsp_done`. `rsp_done` is high in the cycle after the (`ACC_CYC`+`TA_CYC`)-th rising edge following the accepting edge.
- R4: A write spends one setup cycle with chip select low and write enable high. It then holds write enable low for WPE = max(`WP_CYC`, `DS_CYC`-1) cycles, and at least `WP_CYC` cycles. It ends with one hold cycle in which write enable is high and chip select is still low. `rsp_done` is high in the cycle after the (WPE+2)-th rising edge following the accepting edge.
- R5: During a write the controller drives the request byte on the bus unchanged from the setup cycle through the hold cycle. The byte is therefore stable for at least `DS_CYC` cycles before write enable rises, and the RAM stores exactly that byte.
- R6: The controller drives the data bus only while output enable is high, and write enable is low only while chip select is low.
- R7: After any read, chip select and output enable both stay high for at least `TA_CYC` cycles before the next command pulls chip select low.
- R8: The address changes only while chip select is high. It becomes valid no later than the edge at which chip select falls, and holds for as long as chip select stays low.
- R9: A read returns the byte most recently written to that address, including after a back-to-back sequence in which each request is accepted in the done cycle of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request accepted when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8 | Byte read, valid with `rsp_done` |
| mem_addr | output | 19 | Address pins of the RAM |
| mem_sel_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq | inout | 8 | Shared data bus |

## Verification
The assertions assume that the client follows the handshake and holds `req_valid` and its fields steady only until the accepting edge. They also assume that the RAM drives the bus only while chip select and output enable are low and write enable is high. The bench meets both assumptions. It raises `req_valid` only at a falling edge while `req_ready` is high and drops it after one accepting edge. Its RAM model enables its drivers under exactly that strobe condition and refreshes its output one half-cycle later. The stimulus mixes seeded random reads and writes over a small address pool, so that reads hit written locations. Directed cases cover the two address extremes, read-after-write, write-after-read turnaround and never-written locations.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RD_ACCESS = 3'd1,
        ST_RD_TURN   = 3'd2,
        ST_WR_SETUP  = 3'd3,
        ST_WR_PULSE  = 3'd4,
        ST_WR_HOLD   = 3'd5
    } ctrl_state_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_dq_io.sv
module asram_dq_io #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive_en,
    input  logic [DATA_W-1:0] drive_data,
    input  logic              capture,
    output logic [DATA_W-1:0] rdata,
    inout  wire  [DATA_W-1:0] pad
);

    // one tri-state driver per bus bit
    for (genvar b = 0; b < DATA_W; b++) begin : g_pad
        assign pad[b] = drive_en ? drive_data[b] : 1'bz;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= pad;
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 8,
    parameter int ACC_CYC = 1,
    parameter int WP_CYC  = 1,
    parameter int DS_CYC  = 1,
    parameter int TA_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    inout  wire  [DATA_W-1:0] mem_dq
);

    // write-enable pulse long enough for both pulse width and data setup
    localparam int WPE_CYC = int'(max2(WP_CYC, (DS_CYC > 1) ? DS_CYC - 1 : 1));
    localparam int MAX_CYC = int'(max2(max2(ACC_CYC, WPE_CYC), TA_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] WPE_LD = CNT_W'(WPE_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LD  = CNT_W'(TA_CYC - 1);

    ctrl_state_t       state_q, state_d;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              drv_en_q;
    logic [DATA_W-1:0] wdata_q;
    logic              capture;
    logic              accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = (state_q == ST_RD_ACCESS) && tmr_expired;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_RD_ACCESS: if (tmr_expired) state_d = ST_RD_TURN;
            ST_RD_TURN:   if (tmr_expired) state_d = ST_IDLE;
            ST_WR_SETUP:  state_d = ST_WR_PULSE;
            ST_WR_PULSE:  if (tmr_expired) state_d = ST_WR_HOLD;
            ST_WR_HOLD:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // phase timer load on entry to a timed state
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (state_d != state_q) begin
            unique case (state_d)
                ST_RD_ACCESS: begin tmr_load = 1'b1; tmr_val = ACC_LD; end
                ST_WR_PULSE:  begin tmr_load = 1'b1; tmr_val = WPE_LD; end
                ST_RD_TURN:   begin tmr_load = 1'b1; tmr_val = TA_LD;  end
                default:      ;
            endcase
        end
    end

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // registered pin outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_sel_n <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            drv_en_q  <= 1'b0;
            mem_addr  <= '0;
            wdata_q   <= '0;
            rsp_done  <= 1'b0;
        end else begin
            unique case (state_d)
                ST_IDLE, ST_RD_TURN: begin
                    mem_sel_n <= 1'b1; mem_oe_n <= 1'b1; mem_we_n <= 1'b1; drv_en_q <= 1'b0;
                end
                ST_RD_ACCESS: begin
                    mem_sel_n <= 1'b0; mem_oe_n <= 1'b0; mem_we_n <= 1'b1; drv_en_q <= 1'b0;
                end
                ST_WR_SETUP, ST_WR_HOLD: begin
                    mem_sel_n <= 1'b0; mem_oe_n <= 1'b1; mem_we_n <= 1'b1; drv_en_q <= 1'b1;
                end
                ST_WR_PULSE: begin
                    mem_sel_n <= 1'b0; mem_oe_n <= 1'b1; mem_we_n <= 1'b0; drv_en_q <= 1'b1;
                end
                default: begin
                    mem_sel_n <= 1'b1; mem_oe_n <= 1'b1; mem_we_n <= 1'b1; drv_en_q <= 1'b0;
                end
            endcase
            if (accept) begin
                mem_addr <= req_addr;
                wdata_q  <= req_wdata;
            end
            rsp_done <= (state_d == ST_IDLE) && (state_q != ST_IDLE);
        end
    end

    asram_dq_io #(.DATA_W(DATA_W)) u_dq (
        .clk        (clk),
        .rst_n      (rst_n),
        .drive_en   (drv_en_q),
        .drive_data (wdata_q),
        .capture    (capture),
        .rdata      (rsp_rdata),
        .pad        (mem_dq)
    );

    // ---------------- assertions ----------------
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (mem_sel_n && mem_oe_n && mem_we_n && !drv_en_q && !rsp_done));

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_read_we_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_sel_n));

    assert_wdata_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en_q && $past(drv_en_q)) |-> $stable(wdata_q));

    assert_drive_oe_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en_q |-> mem_oe_n);

    assert_we_within_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_sel_n);

    assert_turn_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> mem_sel_n);

    assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

endmodule

// File: tb/asram_ctrl_tb_top.sv
module asram_ctrl_tb_top;

    localparam int ACC = 3;
    localparam int WP  = 2;
    localparam int DS  = 4;
    localparam int TA  = 2;
    localparam int WPE = (WP > DS - 1) ? WP : DS - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_done;
    logic [7:0]  rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_sel_n, mem_oe_n, mem_we_n;
    wire  [7:0]  mem_dq;

    int errs = 0;
    int checks = 0;

    always #10 clk = ~clk;   // 50 MHz

    asram_ctrl #(.ACC_CYC(ACC), .WP_CYC(WP), .DS_CYC(DS), .TA_CYC(TA)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq(mem_dq)
    );

    function automatic logic [7:0] fill_byte(input logic [18:0] a);
        return a[7:0] ^ a[18:11] ^ 8'h5A;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural RAM model ----------------
    logic [7:0] ram [logic [18:0]];
    logic [7:0] ram_out = '0;
    logic       ram_en;
    assign ram_en = !mem_sel_n && !mem_oe_n && mem_we_n;
    assign mem_dq = ram_en ? ram_out : 8'bz;

    logic        p_sel = 1'b1, p_we = 1'b1;
    logic [18:0] p_addr = '0;
    logic [7:0]  p_dq = '0;
    int wl_cnt = 0, ds_cnt = 0, idle_cnt = 0;
    bit after_read = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            int ds_before;
            ram_out = ram.exists(mem_addr) ? ram[mem_addr] : fill_byte(mem_addr);
            if (!mem_sel_n && !p_sel)
                chk("R8 address held while selected", mem_addr, p_addr);
            ds_before = ds_cnt;
            if (!mem_sel_n && mem_oe_n)
                ds_cnt = (ds_cnt > 0 && mem_dq === p_dq) ? ds_cnt + 1 : 1;
            else
                ds_cnt = 0;
            if (!mem_we_n) begin
                wl_cnt++;
            end else if (!p_we) begin
                chk("R4 write pulse long enough", 32'(wl_cnt >= WP), 32'd1);
                chk("R4 write pulse length", 32'(wl_cnt), 32'(WPE));
                chk("R5 data setup before rise", 32'(ds_before >= DS), 32'd1);
                chk("R4 select low at we rise", 32'(mem_sel_n), 32'd0);
                ram[mem_addr] = mem_dq;
                wl_cnt = 0;
            end
            if (!mem_sel_n && p_sel && after_read) begin
                chk("R7 turnaround idle cycles", 32'(idle_cnt >= TA), 32'd1);
                after_read = 1'b0;
            end
            if (ram_en) begin
                after_read = 1'b1;
                idle_cnt = 0;
            end else if (mem_sel_n && mem_oe_n) begin
                idle_cnt++;
            end
            p_sel = mem_sel_n; p_we = mem_we_n; p_addr = mem_addr; p_dq = mem_dq;
        end
    end

    // ---------------- request driver ----------------
    logic [7:0] shadow [logic [18:0]];

    task automatic do_req(input bit wr, input logic [18:0] a, input logic [7:0] d);
        int k = 0;
        int lim = wr ? WPE + 2 : ACC + TA;
        logic [7:0] exp_rd;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 ready low after accept", 32'(req_ready), 32'd0);
        while (1) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (rsp_done || k > 100) break;
            if (req_ready) chk("R2 ready low while busy", 32'(req_ready), 32'd0);
        end
        chk(wr ? "R4 write latency" : "R3 read latency", 32'(k), 32'(lim));
        chk("R2 ready with done", 32'(req_ready), 32'd1);
        if (wr) begin
            shadow[a] = d;
        end else begin
            exp_rd = shadow.exists(a) ? shadow[a] : fill_byte(a);
            chk("R9 R3 read data", 32'(rsp_rdata), 32'(exp_rd));
        end
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [18:0] pool [4];
        int unsigned r;
        r = $urandom(32'h0001_D5A7);
        pool[0] = 19'h00000; pool[1] = 19'h7FFF0; pool[2] = 19'h2A5C0; pool[3] = 19'h15300;
        repeat (3) @(negedge clk);
        chk("R1 select high in reset", 32'(mem_sel_n), 32'd1);
        chk("R1 oe high in reset", 32'(mem_oe_n), 32'd1);
        chk("R1 we high in reset", 32'(mem_we_n), 32'd1);
        chk("R1 ready in reset", 32'(req_ready), 32'd1);
        chk("R1 done low in reset", 32'(rsp_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 strobes idle after reset", {29'd0, mem_sel_n, mem_oe_n, mem_we_n}, 32'd7);

        // directed corners
        do_req(1'b0, 19'h00123, 8'h00);        // R9 never-written location
        do_req(1'b1, 19'h00000, 8'hA5);
        do_req(1'b0, 19'h00000, 8'h00);
        do_req(1'b1, 19'h7FFFF, 8'h3C);        // top address
        do_req(1'b0, 19'h7FFFF, 8'h00);
        do_req(1'b0, 19'h00000, 8'h00);        // read then write same address (R7)
        do_req(1'b1, 19'h00000, 8'hC3);
        do_req(1'b1, 19'h00000, 8'h18);        // write then write
        do_req(1'b0, 19'h00000, 8'h00);

        // seeded random mix, back-to-back or with idle gaps
        for (int i = 0; i < 400; i++) begin
            logic [18:0] a;
            a = pool[$urandom_range(0, 3)] | 19'($urandom_range(0, 15));
            if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
            do_req(1'($urandom_range(0, 1)), a, 8'($urandom));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule